// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Run-Time Frame Format

This block turns parallel bytes into an asynchronous serial stream on a single line, with no clock sent alongside. Two 8-bit registers stand between the CPU and the wire. The first is a holding register that the CPU writes. The second is a shift register that drives the line. Because there are two, software can load the next character while the current one is still going out. Two flags report the state of the path: one says the holding register is empty, and one says the shift register is idle.

Each frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit (even or odd), then one or two high stop bits. The bit timing comes from a single-cycle enable pulse, `tick16`, that runs at sixteen times the bit rate. The frame format is taken from the configuration inputs at the moment a byte moves into the shift register. Changing those inputs therefore has no effect on a frame that is already being sent.

Top module: `uart_tx_core`

## Requirements
- R1: Out of reset, and whenever no frame is being sent, `txd` is high, `hold_empty` is 1 and `shift_empty` is 1.
- R2: Every frame opens with a low start bit. Every bit of a frame lasts exactly 16 clock cycles in which `tick16` is high; cycles without `tick16` do not advance the line.
- R3: The data bits follow the start bit, least significant bit first. Their count is `cfg_len + 5` (code 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8), and the unused upper bits of the byte are never sent.
- R4: When `cfg_par_en` is 1, a parity bit follows the data bits. It is computed over the sent data bits only. With `cfg_par_odd` = 0 the total number of ones is even; with `cfg_par_odd` = 1 it is odd.
- R5: The frame ends with one high stop bit, or two when `cfg_two_stop` is 1.
- R6: A `wr_en` pulse while `hold_empty` is 1 captures `wr_data`, and `hold_empty` reads 0 in the next cycle. When the holding register is full and the shift register is idle, the byte moves across on the next clock edge: in the following cycle `hold_empty` is 1 and `shift_empty` is 0.
- R7: A byte held during a frame starts its own start bit in the cycle right after the last stop bit of that frame ends, with no idle gap. `shift_empty` rises only after a last stop bit ends with the holding register empty.
- R8: A `wr_en` pulse while `hold_empty` is 0 is ignored, and the byte already held is the one that gets sent.
- R9: The configuration inputs are sampled only when a byte enters the shift register. A change in the middle of a frame applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| cfg_len | input | 2 | Data length code (value + 5 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | No frame is in progress |

## Verification
The assertions assume that `tick16` is a single-cycle enable sampled on the clock. They also assume that `wr_en` matters only at clock edges and that a write is judged against the `hold_empty` value visible in that cycle. The stimulus meets these assumptions by changing every input half a cycle away from the active edge. It drives `tick16` either on every cycle or on every third cycle, and it pulses `wr_en` for exactly one cycle. Some writes are deliberately issued while the holding register is full, and some configuration changes land in the middle of a frame. This checks that such events leave the held byte and the frame in progress untouched.

// File: rtl/uart_tx_pkg.sv
// Package: shared types for the serial transmitter.
// Assumes a data length code of two bits (5..8 data bits).
package uart_tx_pkg;

    localparam int LEN_CODE_W = 2;

    // Position within a frame.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    // Frame format, latched at the start of each frame.
    typedef struct packed {
        logic [LEN_CODE_W-1:0] len_code;
        logic                  par_en;
        logic                  par_odd;
        logic                  two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_holdreg.sv
// Holding register: takes one byte from the CPU side and keeps it until
// the framer takes it. Assumes take is asserted only while full is set.
module uart_tx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Capture a byte when empty; clear on handover to the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

endmodule

// File: rtl/uart_tx_bittimer.sv
// Bit timer: counts oversampling ticks and flags the final tick of each
// bit period. Assumes tick is a single-cycle enable.
module uart_tx_bittimer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic bit_end
);

    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] cnt;

    // The bit ends on the last tick of the period.
    assign bit_end = run && tick && (cnt == LAST);

    // Count ticks while a frame runs; a restart clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_parity.sv
// Parity generator: XOR of the low nbits bits of data, inverted for odd
// parity. Assumes nbits never exceeds DATA_W.
module uart_tx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]               data,
    input  logic [$clog2(DATA_W+1)-1:0]     nbits,
    input  logic                            odd,
    output logic                            par
);

    localparam int BITS_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] masked;

    // Keep only the bits that appear on the line.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] & (nbits > BITS_W'(i));
    end

    // Even parity makes the count of ones even; odd inverts it.
    assign par = (^masked) ^ odd;

endmodule

// File: rtl/uart_tx_framer.sv
// Framer: the shift register and the frame sequencer. It loads a byte from
// the holding register when idle, or on the last stop bit so that frames
// follow each other with no gap. Assumes bit_end comes from a timer that is
// restarted on every load.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  frame_cfg_t        cfg,
    input  logic              bit_end,
    output logic              take,
    output logic              busy,
    output logic              txd
);

    localparam int BITS_W = $clog2(DATA_W + 1);

    tx_state_e         state;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] shreg;
    logic [BITS_W-1:0] data_cnt;
    logic              stop_cnt;
    logic              par_q;
    logic              par_in;
    logic [BITS_W-1:0] nbits_in;
    logic [BITS_W-1:0] nbits_q;
    logic              last_stop_end;

    // Data length of the incoming frame and of the frame in progress.
    assign nbits_in = BITS_W'(MIN_BITS) + BITS_W'(cfg.len_code);
    assign nbits_q  = BITS_W'(MIN_BITS) + BITS_W'(cfg_q.len_code);

    // Parity is fixed at load time, from the incoming byte and format.
    uart_tx_parity #(
        .DATA_W (DATA_W)
    ) u_parity (
        .data  (hold_data),
        .nbits (nbits_in),
        .odd   (cfg.par_odd),
        .par   (par_in)
    );

    // The final stop bit ends on this cycle.
    assign last_stop_end = (state == ST_STOP) && bit_end
                         && (stop_cnt == cfg_q.two_stop);

    // Handover: from idle, or right behind the last stop bit.
    assign take = hold_full && ((state == ST_IDLE) || last_stop_end);
    assign busy = (state != ST_IDLE);

    // Step through the frame and shift data toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            shreg    <= '0;
            data_cnt <= '0;
            stop_cnt <= 1'b0;
            par_q    <= 1'b0;
        end else if (take) begin
            state    <= ST_START;
            cfg_q    <= cfg;
            shreg    <= hold_data;
            data_cnt <= '0;
            stop_cnt <= 1'b0;
            par_q    <= par_in;
        end else if (bit_end) begin
            unique case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    shreg    <= shreg >> 1;
                    data_cnt <= data_cnt + 1'b1;
                    if (data_cnt == nbits_q - 1'b1) begin
                        state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                    end
                end
                ST_PARITY: state <= ST_STOP;
                ST_STOP: begin
                    if (last_stop_end) begin
                        state <= ST_IDLE;
                    end else begin
                        stop_cnt <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line level for the current position in the frame.
    always_comb begin
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_core.sv
// Top of the double-buffered serial transmitter. It wires the holding
// register, bit timer and framer together. Assumes tick16 runs at
// OVERSAMPLE times the bit rate and is one cycle wide.
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int MIN_BITS   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick16,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [LEN_CODE_W-1:0] cfg_len,
    input  logic                  cfg_par_en,
    input  logic                  cfg_par_odd,
    input  logic                  cfg_two_stop,
    output logic                  txd,
    output logic                  hold_empty,
    output logic                  shift_empty
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;
    logic              bit_end;
    frame_cfg_t        cfg;

    // Gather the format inputs into one word.
    assign cfg = '{len_code: cfg_len, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    uart_tx_holdreg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_bittimer #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (take),
        .tick    (tick16),
        .bit_end (bit_end)
    );

    uart_tx_framer #(
        .DATA_W   (DATA_W),
        .MIN_BITS (MIN_BITS)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cfg       (cfg),
        .bit_end   (bit_end),
        .take      (take),
        .busy      (busy),
        .txd       (txd)
    );

    assign hold_empty  = !hold_full;
    assign shift_empty = !busy;

endmodule

// File: rtl/uart_tx_core_chk.sv
// Checker for uart_tx_core: port-level timing properties plus the held byte.
// Attached by the bind at the end of this file.
module uart_tx_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic              wr_en,
    input logic              txd,
    input logic              hold_empty,
    input logic              shift_empty,
    input logic [DATA_W-1:0] hold_q
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);  // R1

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !txd);  // R2

    AST_LINE_WAITS_FOR_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_empty && !$past(shift_empty) && !$past(tick16)) |-> $stable(txd));  // R2

    AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> !hold_empty);  // R6

    AST_HANDOVER_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && shift_empty) |=> (hold_empty && !shift_empty));  // R6

    AST_IDLE_ONLY_WHEN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_empty) |-> $past(hold_empty));  // R7

    AST_HELD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && $past(!hold_empty)) |-> $stable(hold_q));  // R8

endmodule

bind uart_tx_core uart_tx_core_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (tick16),
    .wr_en       (wr_en),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty),
    .hold_q      (hold_data)
);

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       txd, hold_empty, shift_empty;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string focus = "";

    // Reference model state.
    bit       m_hold_full;
    bit [7:0] m_hold_byte;
    bit       m_busy;
    int       m_ticks;
    bit       m_bits[$];
    string    m_tags[$];

    always #4 clk = ~clk;  // 125 MHz

    uart_tx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Build the expected bit list for one frame.
    task automatic m_load(bit [7:0] d);
        int n;
        bit p;
        string dtag;
        n = int'(cfg_len) + 5;
        dtag = (focus == "") ? "R3" : focus;
        m_bits.push_back(1'b0); m_tags.push_back("R2");
        p = cfg_par_odd;
        for (int i = 0; i < n; i++) begin
            m_bits.push_back(d[i]); m_tags.push_back(dtag);
            p ^= d[i];
        end
        if (cfg_par_en) begin
            m_bits.push_back(p); m_tags.push_back((focus == "") ? "R4" : focus);
        end
        m_bits.push_back(1'b1); m_tags.push_back("R5");
        if (cfg_two_stop) begin
            m_bits.push_back(1'b1); m_tags.push_back("R5");
        end
    endtask

    // Reference model: advances once per clock from the inputs seen at the edge.
    always @(posedge clk) begin
        bit hf_old;
        bit [7:0] hb_old;
        cyc++;
        if (!rst_n) begin
            m_hold_full = 0; m_hold_byte = 0; m_busy = 0; m_ticks = 0;
            m_bits.delete(); m_tags.delete();
        end else begin
            hf_old = m_hold_full;
            hb_old = m_hold_byte;
            if (m_busy && tick16) begin
                m_ticks++;
                if (m_ticks == 16) begin
                    m_ticks = 0;
                    void'(m_bits.pop_front());
                    void'(m_tags.pop_front());
                    if (m_bits.size() == 0) m_busy = 0;
                end
            end
            if (wr_en && !hf_old) begin
                m_hold_full = 1; m_hold_byte = wr_data;
            end
            if (!m_busy && hf_old) begin
                m_load(hb_old);
                m_busy = 1; m_ticks = 0; m_hold_full = 0;
            end
        end
    end

    // Compare on every cycle, half a period after the edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(m_busy ? m_tags[0] : "R1", "txd", int'(txd), m_busy ? int'(m_bits[0]) : 1);
            check("R6", "hold_empty", int'(hold_empty), int'(!m_hold_full));
            check("R7", "shift_empty", int'(shift_empty), int'(!m_busy));
        end
    end

    // Oversampling enable, every tick_div cycles.
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            tick16 <= 1'b1;
            tick_cnt = 0;
        end else begin
            tick16 <= (tick_cnt == 0);
            tick_cnt = (tick_cnt + 1) % tick_div;
        end
    end

    task automatic put(bit [7:0] d);
        @(negedge clk);
        wr_en <= 1'b1; wr_data <= d;
        @(negedge clk);
        wr_en <= 1'b0;
    endtask

    task automatic wait_hold_empty();
        for (int i = 0; i < 5000 && !hold_empty; i++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 8000 && (m_busy || m_hold_full); i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset txd", int'(txd), 1);
        check("R1", "reset hold_empty", int'(hold_empty), 1);
        check("R1", "reset shift_empty", int'(shift_empty), 1);
        rst_n <= 1'b1;
        chk_on = 1'b1;

        // R3, R5: eight data bits, no parity, one stop
        cfg_len <= 2'd3; cfg_par_en <= 0; cfg_two_stop <= 0;
        put(8'hA5); wait_done();

        // R3, R4: five bits, even parity; upper bits of F3 are not sent
        cfg_len <= 2'd0; cfg_par_en <= 1; cfg_par_odd <= 0;
        put(8'hF3); wait_done();

        // R2, R4, R5: seven bits, odd parity, two stops, sparse ticks
        tick_div = 3;
        cfg_len <= 2'd2; cfg_par_odd <= 1; cfg_two_stop <= 1;
        put(8'h5C); wait_done();
        tick_div = 1;

        // R7: second byte held during the first frame, sent back to back
        cfg_len <= 2'd1; cfg_par_odd <= 0;
        put(8'h3E); wait_hold_empty(); put(8'h81); wait_done();

        // R8: write while holding full is dropped
        focus = "R8";
        cfg_len <= 2'd3; cfg_par_en <= 0; cfg_two_stop <= 0;
        put(8'h11); wait_hold_empty(); put(8'h22);
        check("R8", "hold full before extra write", int'(hold_empty), 0);
        put(8'h33); wait_done();

        // R9: format change mid-frame applies to the next frame only
        focus = "R9";
        cfg_par_en <= 1; cfg_par_odd <= 1;
        put(8'h6A);
        for (int i = 0; i < 40; i++) @(negedge clk);
        check("R9", "frame running at format change", int'(shift_empty), 0);
        cfg_len <= 2'd0; cfg_par_en <= 0; cfg_two_stop <= 1;
        wait_hold_empty(); put(8'h47); wait_done();
        focus = "";

        check("R1", "final txd", int'(txd), 1);
        check("R1", "final shift_empty", int'(shift_empty), 1);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule